// File: doc/BRIEF.md
# Frame-Boundary Double-Buffered Configuration Bank

This block holds the configuration of a display controller with several overlay windows. Every register has two copies. Software writes the staging copy. The active copy drives the display pipeline. Staging values move into the active copies only on a vertical-sync pulse, and only after software has armed the move with a commit request. A new frame therefore always starts with a complete, consistent set of settings, never a half-written one.

Each window has a hold bit. While a window's hold bit is set, that window keeps its old active values across vsync, so a multi-register change can be built up safely. Once the hold bit is cleared, the window's pending values transfer at the next vsync without a fresh request. The main control register has two parts: a run bit that takes effect at once, and a frame-synchronous run bit that takes effect at vsync. The display runs only when both are set. A self-clearing soft-reset bit returns every register to zero. Reads return the staging copy, or the active copy when `rd_active` is high, so the moment of latching can be seen.

Top module: `shadow_reg_bank`

## Requirements
- R1: After `rst`, every staging and active value, the hold bits, the commit state, `win_on`, `video_run` and `bus_rdata` are zero.
- R2: A write to a window register changes its staging readback from the next read onward. Its active copy does not change without a vsync that finds a commit pending for that window.
- R3: A vsync pulse sampled while a commit is pending for an unheld window copies all of that window's staging registers to active. The new value shows on `win_cfg_act` right after that clock edge. Window w register r sits at address 4+2w+r, and `win_cfg_act` slice ((w*2)+r)*16 carries it.
- R4: Writing bit 0 of the commit register (address 2) arms a transfer. Reading that bit returns 1 while any transfer is still pending, and 0 once every armed window and the main register have transferred.
- R5: While bit w of the hold register (address 1) is set, vsync leaves window w's active values unchanged and the window stays pending, while other windows still transfer. After bit w is cleared, the next vsync transfers window w with no new commit.
- R6: Clearing bit 0 (enable) of a window's first register keeps `win_on[w]` high until the vsync transfer that carries the cleared value.
- R7: In the main register (address 0), bit 0 (immediate run) is effective at once. Bit 1 (frame-synchronous run) reaches its active copy only at a committed vsync. `video_run` is high when both the immediate bit and the active bit 1 are set. Reading address 0 with `rd_active` high returns the active bit 1.
- R8: Writing the main register with bit 2 set clears all registers, hold bits and pending commits at that clock edge.
- R9: A write in the same cycle as vsync lands in staging while active takes the previous staging value. A commit written in the vsync cycle arms the following vsync.
- R10: `bus_rdata` is registered and shows the register addressed in the previous cycle. Address 3 and addresses above the last window register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | One-cycle frame boundary pulse |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register word address for read and write |
| bus_wdata | input | DATA_W | Write data |
| rd_active | input | 1 | Read the active copy instead of staging |
| bus_rdata | output | DATA_W | Registered read data |
| video_run | output | 1 | Display running |
| win_on | output | NUM_WIN | Active enable bit of each window |
| win_cfg_act | output | NUM_WIN*REGS_PER_WIN*DATA_W | Active copies of all window registers |

## Verification
The assertions assume that `vsync` is a clean one-cycle pulse in the clock domain. They also assume that only a vsync or a soft-reset write may move active state. The bench raises vsync for a single cycle between negative edges, and it issues soft reset only through the main register. A near-exhaustive sweep covers every hold mask, each with and without a commit. A bench-side model predicts each window's active values from the rules above. Targeted cases cover same-cycle writes and commits at vsync, delayed enable clearing, the two-part run control, and soft reset.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int MAIN_ADDR      = 0;
  localparam int HOLD_ADDR      = 1;
  localparam int COMMIT_ADDR    = 2;
  localparam int WIN_BASE       = 4;
  localparam int RUN_NOW_BIT    = 0;
  localparam int RUN_SYNC_BIT   = 1;
  localparam int SRST_BIT       = 2;
  localparam int COMMIT_BIT     = 0;
  localparam int WIN_ENABLE_BIT = 0;
endpackage

// File: rtl/shadow_win_bank.sv
module shadow_win_bank #(
  parameter int DATA_W = 16,
  parameter int REGS   = 2
) (
  input  logic                   clk,
  input  logic                   clr,
  input  logic                   xfer,
  input  logic [REGS-1:0]        wr_sel,
  input  logic [DATA_W-1:0]      wdata,
  output logic [REGS*DATA_W-1:0] stg_flat,
  output logic [REGS*DATA_W-1:0] act_flat
);
  for (genvar r = 0; r < REGS; r++) begin : g_reg
    logic [DATA_W-1:0] stg_q;
    logic [DATA_W-1:0] act_q;
    always_ff @(posedge clk) begin
      if (clr) begin
        stg_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_sel[r]) stg_q <= wdata;
        if (xfer)      act_q <= stg_q;
      end
    end
    assign stg_flat[r*DATA_W +: DATA_W] = stg_q;
    assign act_flat[r*DATA_W +: DATA_W] = act_q;
  end
endmodule

// File: rtl/shadow_sync_ctrl.sv
module shadow_sync_ctrl #(
  parameter int NUM_WIN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vsync,
  input  logic               wr_main,
  input  logic               wr_hold,
  input  logic               wr_commit,
  input  logic [2:0]         main_bits,
  input  logic [NUM_WIN-1:0] hold_bits,
  input  logic               commit_bit,
  output logic               clr,
  output logic               run_now,
  output logic               run_sync_stg,
  output logic               run_sync_act,
  output logic [NUM_WIN-1:0] hold,
  output logic               pending,
  output logic [NUM_WIN-1:0] win_xfer
);
  import shadow_pkg::*;

  logic               glob_pend_q;
  logic [NUM_WIN-1:0] win_pend_q;
  logic               commit_req;
  logic               glob_xfer;

  assign clr        = rst | (wr_main & main_bits[SRST_BIT]);
  assign commit_req = wr_commit & commit_bit;
  assign glob_xfer  = vsync & glob_pend_q;
  assign win_xfer   = {NUM_WIN{vsync}} & win_pend_q & ~hold;
  assign pending    = glob_pend_q | (|win_pend_q);

  always_ff @(posedge clk) begin
    if (clr) begin
      run_now      <= 1'b0;
      run_sync_stg <= 1'b0;
      run_sync_act <= 1'b0;
      hold         <= '0;
      glob_pend_q  <= 1'b0;
      win_pend_q   <= '0;
    end else begin
      if (wr_main) begin
        run_now      <= main_bits[RUN_NOW_BIT];
        run_sync_stg <= main_bits[RUN_SYNC_BIT];
      end
      if (glob_xfer) run_sync_act <= run_sync_stg;
      if (wr_hold)   hold <= hold_bits;
      glob_pend_q <= (glob_pend_q & ~vsync) | commit_req;
      win_pend_q  <= (win_pend_q & ~win_xfer) | {NUM_WIN{commit_req}};
    end
  end
endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank #(
  parameter int NUM_WIN      = 2,
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 4,
  parameter int REGS_PER_WIN = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   vsync,
  input  logic                                   bus_wr,
  input  logic [ADDR_W-1:0]                      bus_addr,
  input  logic [DATA_W-1:0]                      bus_wdata,
  input  logic                                   rd_active,
  output logic [DATA_W-1:0]                      bus_rdata,
  output logic                                   video_run,
  output logic [NUM_WIN-1:0]                     win_on,
  output logic [NUM_WIN*REGS_PER_WIN*DATA_W-1:0] win_cfg_act
);
  import shadow_pkg::*;

  localparam int WIN_W  = REGS_PER_WIN * DATA_W;
  localparam int N_WREG = NUM_WIN * REGS_PER_WIN;

  logic               wr_main, wr_hold, wr_commit;
  logic [N_WREG-1:0]  win_wr;
  logic               clr, run_now, run_sync_stg, run_sync_act, pending;
  logic [NUM_WIN-1:0] hold_vec, win_xfer;
  logic [N_WREG*DATA_W-1:0] stg_all, act_all;
  logic [DATA_W-1:0]  rd_next;

  assign wr_main   = bus_wr && (bus_addr == ADDR_W'(MAIN_ADDR));
  assign wr_hold   = bus_wr && (bus_addr == ADDR_W'(HOLD_ADDR));
  assign wr_commit = bus_wr && (bus_addr == ADDR_W'(COMMIT_ADDR));

  always_comb begin
    for (int i = 0; i < N_WREG; i++)
      win_wr[i] = bus_wr && (bus_addr == ADDR_W'(WIN_BASE + i));
  end

  shadow_sync_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .clk(clk), .rst(rst), .vsync(vsync),
    .wr_main(wr_main), .wr_hold(wr_hold), .wr_commit(wr_commit),
    .main_bits(bus_wdata[2:0]), .hold_bits(bus_wdata[NUM_WIN-1:0]),
    .commit_bit(bus_wdata[COMMIT_BIT]),
    .clr(clr), .run_now(run_now), .run_sync_stg(run_sync_stg),
    .run_sync_act(run_sync_act), .hold(hold_vec), .pending(pending),
    .win_xfer(win_xfer)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    shadow_win_bank #(.DATA_W(DATA_W), .REGS(REGS_PER_WIN)) u_bank (
      .clk(clk), .clr(clr), .xfer(win_xfer[w]),
      .wr_sel(win_wr[w*REGS_PER_WIN +: REGS_PER_WIN]),
      .wdata(bus_wdata),
      .stg_flat(stg_all[w*WIN_W +: WIN_W]),
      .act_flat(act_all[w*WIN_W +: WIN_W])
    );
    assign win_on[w] = act_all[w*WIN_W + WIN_ENABLE_BIT];
  end

  assign win_cfg_act = act_all;
  assign video_run   = run_now & run_sync_act;

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(MAIN_ADDR)) begin
      rd_next[RUN_NOW_BIT]  = run_now;
      rd_next[RUN_SYNC_BIT] = rd_active ? run_sync_act : run_sync_stg;
    end
    if (bus_addr == ADDR_W'(HOLD_ADDR))   rd_next[NUM_WIN-1:0] = hold_vec;
    if (bus_addr == ADDR_W'(COMMIT_ADDR)) rd_next[COMMIT_BIT]  = pending;
    for (int i = 0; i < N_WREG; i++)
      if (bus_addr == ADDR_W'(WIN_BASE + i))
        rd_next = rd_active ? act_all[i*DATA_W +: DATA_W] : stg_all[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/shadow_reg_bank_chk.sv
module shadow_reg_bank_chk #(
  parameter int NUM_WIN      = 2,
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 4,
  parameter int REGS_PER_WIN = 2
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   vsync,
  input logic                                   bus_wr,
  input logic [ADDR_W-1:0]                      bus_addr,
  input logic                                   wdata_srst,
  input logic [NUM_WIN-1:0]                     hold,
  input logic                                   video_run,
  input logic [NUM_WIN-1:0]                     win_on,
  input logic [NUM_WIN*REGS_PER_WIN*DATA_W-1:0] win_cfg_act
);
  localparam int WIN_W = REGS_PER_WIN * DATA_W;

  logic main_wr, srst_wr;
  assign main_wr = bus_wr && (bus_addr == ADDR_W'(shadow_pkg::MAIN_ADDR));
  assign srst_wr = main_wr && wdata_srst;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (win_cfg_act == '0 && win_on == '0 && !video_run));

  // R2
  a_r2_active_needs_vsync: assert property (@(posedge clk) disable iff (rst)
    (!vsync && !srst_wr) |=> $stable(win_cfg_act));

  // R5
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_hold
    a_r5_hold_blocks: assert property (@(posedge clk) disable iff (rst)
      (vsync && hold[w] && !srst_wr) |=> $stable(win_cfg_act[w*WIN_W +: WIN_W]));
  end

  // R6
  a_r6_enable_moves_at_vsync: assert property (@(posedge clk) disable iff (rst)
    (win_on != $past(win_on)) |-> $past(vsync || srst_wr));

  // R7
  a_r7_run_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(video_run) |-> $past(vsync || main_wr));
endmodule

bind shadow_reg_bank shadow_reg_bank_chk #(
  .NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REGS_PER_WIN(REGS_PER_WIN)
) u_chk (
  .clk(clk), .rst(rst), .vsync(vsync), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata_srst(bus_wdata[shadow_pkg::SRST_BIT]), .hold(hold_vec),
  .video_run(video_run), .win_on(win_on), .win_cfg_act(win_cfg_act)
);

// File: tb/test_shadow_reg_bank.sv
`timescale 1ns/1ps
module test_shadow_reg_bank;
  localparam int NW = 2, DW = 16, AW = 4, RPW = 2;

  logic clk = 1'b0, rst = 1'b1, vsync = 1'b0, bus_wr = 1'b0, rd_active = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic video_run;
  logic [NW-1:0] win_on;
  logic [NW*RPW*DW-1:0] win_cfg_act;

  shadow_reg_bank #(.NUM_WIN(NW), .DATA_W(DW), .ADDR_W(AW), .REGS_PER_WIN(RPW)) i_shadow_reg_bank (
    .clk(clk), .rst(rst), .vsync(vsync), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_active(rd_active), .bus_rdata(bus_rdata),
    .video_run(video_run), .win_on(win_on), .win_cfg_act(win_cfg_act)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] m_stg [NW][RPW];
  logic [DW-1:0] m_act [NW][RPW];
  logic [NW-1:0] m_hold, m_pw;
  logic m_pg, m_now, m_rs_stg, m_rs_act;

  task automatic model_clear();
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < RPW; r++) begin m_stg[w][r] = '0; m_act[w][r] = '0; end
    m_hold = '0; m_pw = '0; m_pg = 0; m_now = 0; m_rs_stg = 0; m_rs_act = 0;
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // one clock cycle of stimulus, with the model advanced in step
  task automatic cyc(input logic wr, input int a, input logic [DW-1:0] d, input logic vs);
    if (vs) begin
      for (int w = 0; w < NW; w++)
        if (m_pw[w] && !m_hold[w]) begin
          for (int r = 0; r < RPW; r++) m_act[w][r] = m_stg[w][r];
          m_pw[w] = 0;
        end
      if (m_pg) m_rs_act = m_rs_stg;
      m_pg = 0;
    end
    if (wr) begin
      if (a == 0) begin
        if (d[2]) model_clear();
        else begin m_now = d[0]; m_rs_stg = d[1]; end
      end else if (a == 1) m_hold = d[NW-1:0];
      else if (a == 2) begin
        if (d[0]) begin m_pg = 1; m_pw = '1; end
      end else if (a >= 4 && a < 4 + NW*RPW) m_stg[(a-4)/RPW][(a-4)%RPW] = d;
    end
    bus_wr = wr; bus_addr = AW'(a); bus_wdata = d; vsync = vs;
    @(posedge clk); @(negedge clk);
    bus_wr = 0; vsync = 0;
  endtask

  task automatic rd(input int a, input logic act, output logic [DW-1:0] q);
    bus_addr = AW'(a); rd_active = act;
    @(posedge clk); @(negedge clk);
    q = bus_rdata;
    rd_active = 0;
  endtask

  task automatic check_active(input string tag);
    for (int w = 0; w < NW; w++) begin
      for (int r = 0; r < RPW; r++)
        chk(tag, win_cfg_act[((w*RPW)+r)*DW +: DW], m_act[w][r]);
      chk({tag, " R6 win_on"}, DW'(win_on[w]), DW'(m_act[w][0][0]));
    end
    chk({tag, " R7 video_run"}, DW'(video_run), DW'(m_now & m_rs_act));
  endtask

  task automatic check_commit(input string tag);
    logic [DW-1:0] q;
    rd(2, 0, q);
    chk({tag, " R4 commit"}, q, DW'(m_pg | (|m_pw)));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state, R10 map
    check_active("R1 reset");
    chk("R1 rdata", bus_rdata, '0);
    for (int a = 0; a < 8; a++) begin
      rd(a, 0, q); chk("R1 staging read", q, '0);
      rd(a, 1, q); chk("R1 active read", q, '0);
    end

    // sweep over hold masks, with and without commit
    for (int it = 0; it < 8; it++) begin
      int hm = it >> 1;
      int rq = it & 1;
      for (int w = 0; w < NW; w++)
        for (int r = 0; r < RPW; r++)
          cyc(1, 4 + w*RPW + r, DW'(it*4099 + w*257 + r*31 + it + w + 1), 0);
      for (int i = 0; i < NW*RPW; i++) begin
        rd(4 + i, 0, q); chk("R2 staging readback", q, m_stg[i/RPW][i%RPW]);
      end
      check_active("R2 no transfer before vsync");
      cyc(1, 1, DW'(hm), 0);
      if (rq != 0) cyc(1, 2, 16'h0001, 0);
      check_commit("R4 armed");
      cyc(0, 0, 0, 1);
      check_active("R2 R3 R5 after vsync");
      check_commit("R4 after vsync");
      cyc(1, 1, 16'h0000, 0);
      check_active("R5 release before vsync");
      cyc(0, 0, 0, 1);
      check_active("R5 after release vsync");
      check_commit("R4 drained");
    end

    // R6: enable cleared waits for vsync
    cyc(1, 4, 16'h0001, 0); cyc(1, 2, 16'h0001, 0); cyc(0, 0, 0, 1);
    check_active("R6 enabled");
    cyc(1, 4, 16'h0000, 0);
    repeat (3) @(negedge clk);
    check_active("R6 still on");
    cyc(1, 2, 16'h0001, 0); cyc(0, 0, 0, 1);
    check_active("R6 off after vsync");

    // R7: two-part run control
    cyc(1, 0, 16'h0001, 0);
    check_active("R7 immediate only");
    cyc(1, 0, 16'h0003, 0);
    check_active("R7 sync staged");
    rd(0, 0, q); chk("R7 main staging", q, 16'h0003);
    rd(0, 1, q); chk("R7 main active", q, 16'h0001);
    cyc(1, 2, 16'h0001, 0); cyc(0, 0, 0, 1);
    check_active("R7 running");
    rd(0, 1, q); chk("R7 main active after vsync", q, 16'h0003);

    // R9: write and commit coinciding with vsync
    cyc(1, 6, 16'hA5A5, 0); cyc(1, 2, 16'h0001, 0);
    cyc(1, 6, 16'h5A5A, 1);
    check_active("R9 old staging latched");
    rd(6, 0, q); chk("R9 staging holds new", q, 16'h5A5A);
    check_commit("R9 cleared");
    cyc(1, 2, 16'h0001, 1);
    check_active("R9 commit at vsync");
    check_commit("R9 armed for next");
    cyc(0, 0, 0, 1);
    check_active("R9 applied next vsync");
    rd(6, 1, q); chk("R9 active readback", q, 16'h5A5A);

    // R10: unmapped addresses
    cyc(1, 3, 16'hFFFF, 0);
    rd(3, 0, q); chk("R10 addr 3", q, '0);
    rd(15, 1, q); chk("R10 addr 15", q, '0);
    rd(9, 0, q); chk("R10 addr 9", q, '0);

    // R8: soft reset
    cyc(1, 1, 16'h0003, 0); cyc(1, 2, 16'h0001, 0);
    cyc(1, 0, 16'h0004, 0);
    check_active("R8 soft reset");
    for (int a = 0; a < 8; a++) begin
      rd(a, 0, q); chk("R8 staging cleared", q, '0);
      rd(a, 1, q); chk("R8 active cleared", q, '0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule